// File: doc/BRIEF.md
# Armed Pulse Latch

This block produces a single held level that goes high on the first rising edge of a pulse train, but only while a separate arm level is present. Once high, the output ignores the pulse input entirely. It drops back low only when the arm level is withdrawn. A later rising edge can set it again, provided the block is armed once more by then.

Both the pulse input and the arm input are asynchronous to the block's sampling clock. Each passes through its own flop synchronizer. Rising edges on the pulse input are then found by comparing the synchronized sample with the one from the previous cycle. Because the block sets on an edge and not on a level, a pulse that is already high when the block is armed does not set the output. The target pulse train has pulses of a few microseconds at a rate of a few kilohertz. The output has to follow a qualifying edge within tens of microseconds, and a clock in the megahertz range or faster meets both of these limits with a wide margin.

Top module: `armed_pulse_latch`

## Requirements
- R1: While rst_n is low, hold_o is low, and it goes low without waiting for a clock edge. After rst_n rises, the block ignores its inputs for the first two rising clock edges.
- R2: Suppose arm_i is high and pulse_i is first sampled high at rising clock edge k, after being sampled low at edge k-1. Then hold_o is high after edge k+2. This is three clock cycles, far inside the 80 us limit.
- R3: A rising edge on pulse_i that is sampled while arm_i is sampled low leaves hold_o low.
- R4: Once hold_o is high, it stays high for as long as arm_i stays high, whatever pulse_i does.
- R5: If arm_i is first sampled low at rising edge k, hold_o is low after edge k+2. It stays low until a later qualifying edge sets it.
- R6: If arm_i is sampled low at the same edge as the second of the two pulse_i samples that form a rising edge, hold_o does not go high. The clear wins.
- R7: The output is set only by an edge. If pulse_i is already high when arm_i rises, hold_o stays low until pulse_i has fallen and risen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| pulse_i | input | 1 | Asynchronous pulse train |
| arm_i | input | 1 | Asynchronous arm level; high allows a set, low clears |
| hold_o | output | 1 | Latched output level |

## Verification
The assertions assume that each input level lasts long enough to reach the synchronizer outputs. In particular, every pulse must stay high, and every gap must stay low, for at least one full clock cycle. The assertions also assume that reset is released with both inputs low. The stimulus changes inputs only at falling clock edges and holds every level for several cycles. It keeps both inputs low across each reset. The same-edge clash between a pulse rise and an arm fall is produced by changing both inputs in the same cycle.

// File: rtl/apl_pkg.sv
package apl_pkg;
  typedef enum logic {
    LAT_OFF = 1'b0,
    LAT_ON  = 1'b1
  } lat_state_t;
endpackage

// File: rtl/apl_reset_sync.sv
module apl_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/apl_bit_sync.sv
module apl_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/apl_rise_detect.sv
module apl_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/apl_latch_core.sv
module apl_latch_core
  import apl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic armed_i,
  input  logic rise_i,
  output logic hold_o
);
  lat_state_t state_q, state_d;
  logic       state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LAT_OFF: if (armed_i && rise_i) state_d = LAT_ON;
      LAT_ON:  if (!armed_i)          state_d = LAT_OFF;
      default:                        state_d = LAT_OFF;
    endcase
    if (!armed_i) state_d = LAT_OFF;
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= LAT_OFF;
    else if (state_en) state_q <= state_d;
  end

  assign hold_o = (state_q == LAT_ON);
endmodule

// File: rtl/armed_pulse_latch.sv
module armed_pulse_latch #(
  parameter int SYNC_STAGES  = 2,
  parameter int RESET_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  input  logic arm_i,
  output logic hold_o
);
  logic rst_int_n;
  logic pulse_sync;
  logic arm_sync;
  logic pulse_rise;

  apl_reset_sync #(.STAGES(RESET_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_int_n)
  );

  apl_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_pulse (
    .clk(clk), .rst_n(rst_int_n), .d_i(pulse_i), .q_o(pulse_sync)
  );

  apl_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_arm (
    .clk(clk), .rst_n(rst_int_n), .d_i(arm_i), .q_o(arm_sync)
  );

  apl_rise_detect u_rise (
    .clk(clk), .rst_n(rst_int_n), .lvl_i(pulse_sync), .rise_o(pulse_rise)
  );

  apl_latch_core u_core (
    .clk(clk), .rst_n(rst_int_n), .armed_i(arm_sync),
    .rise_i(pulse_rise), .hold_o(hold_o)
  );
endmodule

// File: rtl/apl_checker.sv
module apl_checker (
  input logic clk,
  input logic rst_n,
  input logic rst_int_n,
  input logic armed,
  input logic rise,
  input logic hold
);
  always @(posedge clk) begin
    if (!rst_n) p_reset_low_r1: assert (!hold) else $error("hold high in reset");
  end

  p_set_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    armed && rise |=> hold);

  p_no_set_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !hold && !armed |=> !hold);

  p_stay_high_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    hold && armed |=> hold);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !armed |=> !hold);

  p_edge_only_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !hold && !rise |=> !hold);
endmodule

bind armed_pulse_latch apl_checker u_apl_checker (
  .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n),
  .armed(arm_sync), .rise(pulse_rise), .hold(hold_o)
);

// File: tb/test_armed_pulse_latch.sv
module test_armed_pulse_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_i = 1'b0;
  logic arm_i = 1'b0;
  logic hold_o;

  int checks = 0;
  int failures = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  armed_pulse_latch i_armed_pulse_latch (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .arm_i(arm_i), .hold_o(hold_o)
  );

  // Reference model: history of input samples taken at each rising edge.
  bit ph[$];
  bit eh[$];
  bit model_out = 0;
  int rel_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rel_cnt = 0;
      ph = {0, 0, 0};
      eh = {0, 0, 0};
      model_out = 0;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
      ph = {0, 0, 0};
      eh = {0, 0, 0};
      model_out = 0;
    end else begin
      // ph[0]=k-1, ph[1]=k-2, ph[2]=k-3
      if (!eh[1]) model_out = 0;
      else if (ph[1] && !ph[2]) model_out = 1;
      ph.push_front(pulse_i); void'(ph.pop_back());
      eh.push_front(arm_i);   void'(eh.pop_back());
    end
  end

  task automatic check(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: hold_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) check(phase, hold_o, model_out);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: run hung");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    phase = "R1"; check("R1", hold_o, 1'b0);
    rst_n = 1'b1;
    cyc(5);

    phase = "R3";
    pulse_i = 1; cyc(4); pulse_i = 0; cyc(6);
    check("R3", hold_o, 1'b0);

    phase = "R2";
    arm_i = 1; cyc(6);
    pulse_i = 1;            // sampled at edge k
    @(negedge clk);         // after edge k
    check("R2", hold_o, 1'b0);
    @(negedge clk);         // after edge k+1
    check("R2", hold_o, 1'b0);
    @(negedge clk);         // after edge k+2
    check("R2", hold_o, 1'b1);
    cyc(3); pulse_i = 0;

    phase = "R4";
    for (int i = 0; i < 5; i++) begin
      cyc(3); pulse_i = 1; cyc(2); pulse_i = 0;
    end
    cyc(4);
    check("R4", hold_o, 1'b1);

    phase = "R5";
    arm_i = 0;
    @(negedge clk); check("R5", hold_o, 1'b1);
    @(negedge clk); check("R5", hold_o, 1'b1);
    @(negedge clk); check("R5", hold_o, 1'b0);
    pulse_i = 1; cyc(3); pulse_i = 0; cyc(4);
    check("R5", hold_o, 1'b0);

    phase = "R7";
    pulse_i = 1; cyc(3);
    arm_i = 1; cyc(8);
    check("R7", hold_o, 1'b0);
    pulse_i = 0; cyc(4);
    check("R7", hold_o, 1'b0);
    pulse_i = 1; cyc(4);
    check("R7", hold_o, 1'b1);
    pulse_i = 0; arm_i = 0; cyc(5);

    phase = "R6";
    arm_i = 1; cyc(5);
    pulse_i = 1; arm_i = 0;   // edge and clear seen together
    cyc(6);
    check("R6", hold_o, 1'b0);
    pulse_i = 0; cyc(4);

    phase = "R1";
    arm_i = 1; cyc(4);
    pulse_i = 1; cyc(4);
    check("R1", hold_o, 1'b1);
    pulse_i = 0; arm_i = 0;
    #1.0 rst_n = 0; #0.5;
    check("R1", hold_o, 1'b0);
    cyc(3);
    rst_n = 1; cyc(6);
    check("R1", hold_o, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule